// File: doc/BRIEF.md
# Byte-Realigning AAL5 Cell Segmenter

This block sits on the transmit path between the host-memory fetch logic and the cell output. A packet is presented as a series of 32-bit words. Each word carries a start lane and a count of valid bytes, because the packet may be spread over several host buffers and each buffer may begin at any byte address. The block keeps only the flagged bytes and packs them into one continuous byte stream, so fragments join with no gaps. It also counts the packet length.

When the last byte of a packet has been taken, the block appends zero padding. The padding runs until the packet plus an 8-byte trailer fills a whole number of 48-byte payloads. The block then writes the trailer itself, with two zero control bytes, the 16-bit length and a CRC-32 over the whole padded unit.

Each payload is written into an on-chip store that holds up to eight payloads. The store is drained one byte per accepted cycle on an 8-bit output. That output marks the first byte of every payload and flags every byte of the final payload of a packet, so that downstream header logic can set the end-of-message indication. Input is held off with a ready signal whenever the store has no room for another whole payload.

Top module: `aal5_cell_segmenter`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A word is accepted on a clock edge where in_valid and in_ready are both 1. Byte lane k of in_data is bits [8k+7:8k]. Only lanes in_offset through in_offset+in_count-1 are taken, lowest lane first. in_count is 1 to 4, and the contents of the other lanes have no effect on the output.
- R3: Bytes taken from consecutive words of one packet appear back to back in the output stream, whatever the offsets, so that fragments from different buffers are joined without gaps.
- R4: The output is a sequence of 48-byte payloads. out_first is 1 on the first byte of each payload and 0 on the other 47.
- R5: After the byte taken from a word with in_eop set, zero bytes follow until the position within the current payload is 40. No padding is added when the data already ends at position 40.
- R6: Payload positions 40 to 47 of the last payload carry, in order: 0x00, 0x00, the data length in bytes (high byte, then low byte), and the complemented CRC, most significant byte first.
- R7: The CRC uses polynomial 0x04C11DB7, processed MSB first without reflection. It starts at 0xFFFFFFFF and covers data, padding and trailer positions 40 to 43.
- R8: out_eom is 1 on all 48 bytes of the last payload of a packet, and 0 on the bytes of every other payload.
- R9: The store holds 8 complete payloads without loss. in_ready is 0 while all 8 are occupied.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_first and out_eom hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 32 | Host data word, lane k in bits [8k+7:8k] |
| in_offset | input | 2 | First valid lane of the word |
| in_count | input | 3 | Number of valid lanes, 1 to 4 |
| in_eop | input | 1 | Word holds the last byte of the packet |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | Byte is position 0 of a payload |
| out_eom | output | 1 | Byte belongs to the last payload of a packet |

## Verification
The assertions take for granted that every word obeys in_count from 1 to 4 and in_offset plus in_count no greater than 4. They also assume the consumer only needs stability while it is stalling. The stimulus derives each word's offset and count from the packet and word numbers, clamps the count to the lanes left in the word and to the bytes left in the packet, and fills the unused lanes with junk. It sweeps packet lengths 1 to 100, which covers the exact-fit, one-over and multi-payload padding cases. A separate phase stalls the consumer until the store is full.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int CELL_BYTES = 48;
  localparam int TRAIL_BYTES = 8;
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int TRAIL_POS = CELL_BYTES - TRAIL_BYTES;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [1:0] {PH_DATA, PH_PAD, PH_TRAIL} phase_t;

  // One byte of MSB-first CRC-32 update.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ b[i];
      r = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

  // Last lane of a word from its start lane and count.
  function automatic logic [1:0] end_lane(input logic [1:0] off, input logic [2:0] cnt);
    logic [2:0] s;
    s = {1'b0, off} + cnt - 3'd1;
    return s[1:0];
  endfunction
endpackage

// File: rtl/seg_unpack.sv
module seg_unpack
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic [1:0]  in_offset,
  input  logic [2:0]  in_count,
  input  logic        in_eop,
  input  logic        space,
  input  logic        take,
  output logic        in_ready,
  output logic        b_valid,
  output logic [7:0]  b_data,
  output logic        b_last
);
  logic        held;
  logic [31:0] word_q;
  logic [1:0]  lane_q, stop_q;
  logic        eop_q;

  assign in_ready = !held && space;
  assign b_valid  = held;
  assign b_data   = word_q[{lane_q, 3'b000} +: 8];
  assign b_last   = held && eop_q && (lane_q == stop_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      word_q <= '0;
      lane_q <= '0;
      stop_q <= '0;
      eop_q  <= 1'b0;
    end else if (in_valid && in_ready) begin
      held   <= 1'b1;
      word_q <= in_data;
      lane_q <= in_offset;
      stop_q <= end_lane(in_offset, in_count);
      eop_q  <= in_eop;
    end else if (held && take) begin
      if (lane_q == stop_q) held <= 1'b0;
      else lane_q <= lane_q + 2'd1;
    end
  end
endmodule

// File: rtl/seg_framer.sv
module seg_framer
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             b_valid,
  input  logic [7:0]       b_data,
  input  logic             b_last,
  input  logic             space,
  output logic             take,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_eom,
  output logic             pad_wr,
  output logic             trail_start
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] TPOS = IDX_W'(TRAIL_POS);

  phase_t           ph;
  logic [IDX_W-1:0] pos, pos_nx;
  logic [15:0]      len;
  logic [31:0]      crc;
  logic [2:0]       tidx;
  logic             crc_en;

  assign pos_nx = (pos == LAST_IDX) ? '0 : pos + 1'b1;
  assign tidx   = 3'(pos - TPOS);
  assign take   = (ph == PH_DATA) && space;
  assign wr_en  = space && ((ph != PH_DATA) || b_valid);
  assign wr_idx = pos;
  assign pad_wr = wr_en && (ph == PH_PAD);
  assign trail_start = wr_en && (ph == PH_TRAIL) && (tidx == 3'd0);
  assign wr_eom = wr_en && (ph == PH_TRAIL) && (pos == LAST_IDX);
  assign crc_en = !((ph == PH_TRAIL) && tidx[2]);

  always_comb begin
    wr_data = 8'h00;
    case (ph)
      PH_DATA: wr_data = b_data;
      PH_TRAIL: begin
        case (tidx)
          3'd2: wr_data = len[15:8];
          3'd3: wr_data = len[7:0];
          3'd4: wr_data = ~crc[31:24];
          3'd5: wr_data = ~crc[23:16];
          3'd6: wr_data = ~crc[15:8];
          3'd7: wr_data = ~crc[7:0];
          default: wr_data = 8'h00;
        endcase
      end
      default: wr_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_DATA;
      pos <= '0;
      len <= '0;
      crc <= '1;
    end else if (wr_en) begin
      pos <= pos_nx;
      if (crc_en) crc <= crc_step(crc, wr_data);
      case (ph)
        PH_DATA: begin
          len <= len + 16'd1;
          if (b_last) ph <= (pos_nx == TPOS) ? PH_TRAIL : PH_PAD;
        end
        PH_PAD: if (pos_nx == TPOS) ph <= PH_TRAIL;
        default: if (pos == LAST_IDX) begin
          ph  <= PH_DATA;
          len <= '0;
          crc <= '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_cell_fifo.sv
module seg_cell_fifo
  import seg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_eom,
  input  logic             out_ready,
  output logic             space,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_eom
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH * CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [7:0]       mem [DEPTH*CELL_BYTES];
  logic             eom_q [DEPTH];
  logic [PTR_W-1:0] wcell, rcell;
  logic [IDX_W-1:0] ridx;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] waddr, raddr;
  logic             commit, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign waddr     = ADDR_W'(int'(wcell) * CELL_BYTES + int'(wr_idx));
  assign raddr     = ADDR_W'(int'(rcell) * CELL_BYTES + int'(ridx));
  assign space     = int'(cnt) < DEPTH;
  assign out_valid = cnt != '0;
  assign out_data  = mem[raddr];
  assign out_first = ridx == '0;
  assign out_eom   = eom_q[rcell];
  assign commit    = wr_en && space && (wr_idx == LAST_IDX);
  assign pop       = out_valid && out_ready && (ridx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (wr_en && space) mem[waddr] <= wr_data;
    if (commit) eom_q[wcell] <= wr_eom;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcell <= '0;
      rcell <= '0;
      ridx  <= '0;
      cnt   <= '0;
    end else begin
      if (commit) wcell <= ptr_inc(wcell);
      if (out_valid && out_ready) ridx <= (ridx == LAST_IDX) ? '0 : ridx + 1'b1;
      if (pop) rcell <= ptr_inc(rcell);
      cnt <= cnt + CNT_W'(commit) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/aal5_cell_segmenter.sv
module aal5_cell_segmenter
  import seg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [1:0]  in_offset,
  input  logic [2:0]  in_count,
  input  logic        in_eop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_first,
  output logic        out_eom
);
  logic             fifo_space, take, b_valid, b_last;
  logic [7:0]       b_data, wr_data;
  logic             wr_en, wr_eom, pad_wr, trail_start;
  logic [IDX_W-1:0] wr_idx;

  seg_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_offset(in_offset), .in_count(in_count), .in_eop(in_eop),
    .space(fifo_space), .take(take), .in_ready(in_ready),
    .b_valid(b_valid), .b_data(b_data), .b_last(b_last)
  );

  seg_framer u_framer (
    .clk(clk), .rst_n(rst_n), .b_valid(b_valid), .b_data(b_data),
    .b_last(b_last), .space(fifo_space), .take(take), .wr_en(wr_en),
    .wr_data(wr_data), .wr_idx(wr_idx), .wr_eom(wr_eom),
    .pad_wr(pad_wr), .trail_start(trail_start)
  );

  seg_cell_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_idx(wr_idx), .wr_eom(wr_eom), .out_ready(out_ready),
    .space(fifo_space), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_eom(out_eom)
  );
endmodule

// File: rtl/seg_checker.sv
module seg_checker
  import seg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_first,
  input logic             out_eom,
  input logic             wr_en,
  input logic             fifo_space,
  input logic             pad_wr,
  input logic [7:0]       wr_data,
  input logic             trail_start,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_eom
);
  p_write_has_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> fifo_space);

  p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_first) && $stable(out_eom)));

  p_pad_is_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_wr |-> (wr_data == 8'h00));

  p_trailer_at_40_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_start |-> (wr_idx == IDX_W'(TRAIL_POS)));

  p_eom_on_last_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eom |-> (wr_en && wr_idx == IDX_W'(CELL_BYTES - 1)));
endmodule

bind aal5_cell_segmenter seg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_first(out_first), .out_eom(out_eom),
  .wr_en(wr_en), .fifo_space(fifo_space), .pad_wr(pad_wr),
  .wr_data(wr_data), .trail_start(trail_start), .wr_idx(wr_idx),
  .wr_eom(wr_eom)
);

// File: tb/sim_aal5_cell_segmenter.sv
module sim_aal5_cell_segmenter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0] in_offset = '0;
  logic [2:0] in_count = 3'd1;
  logic in_ready, out_valid, out_first, out_eom;
  logic [7:0] out_data;

  int tests = 0, fails = 0, rcnt = 0;
  bit hold = 1'b0, done = 1'b0;
  logic [9:0] exp_q[$];

  always #10 clk = ~clk;

  aal5_cell_segmenter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_offset(in_offset), .in_count(in_count),
    .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_eom(out_eom)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int pk, input int i);
    return 8'(pk * 37 + i * 11 + 5);
  endfunction

  // Reference CRC: shift the byte into the top, then eight polynomial steps.
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  // R3 R5 R6 R7 R8 R4: expected byte stream of one packet.
  task automatic expect_pkt(input int plen, input int pk);
    int total;
    logic [31:0] c;
    logic [7:0] b;
    total = ((plen + 8 + 47) / 48) * 48;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < total; i++) begin
      if (i < plen) b = pbyte(pk, i);
      else if (i < total - 8) b = 8'h00;
      else if (i == total - 6) b = 8'(plen >> 8);
      else if (i == total - 5) b = 8'(plen);
      else if (i >= total - 4) b = ~c[31 - 8 * (i - (total - 4)) -: 8];
      else b = 8'h00;
      if (i < total - 4) c = ref_crc(c, b);
      exp_q.push_back({(i % 48) == 0, i >= total - 48, b});
    end
  endtask

  task automatic send_pkt(input int plen, input int pk);
    int i, k, off, c;
    expect_pkt(plen, pk);
    i = 0; k = 0;
    while (i < plen) begin
      off = (pk + k) % 4;
      c = 1 + ((pk * 3 + k) % (4 - off));
      if (c > plen - i) c = plen - i;
      @(negedge clk);
      in_valid = 1'b1;
      in_offset = 2'(off);
      in_count = 3'(c);
      in_eop = (i + c == plen);
      for (int l = 0; l < 4; l++)   // R2: junk outside the selected lanes
        in_data[8*l +: 8] = (l >= off && l < off + c) ? pbyte(pk, i + l - off) : 8'(8'hC3 ^ (k * 7 + l));
      while (!in_ready) @(negedge clk);
      i += c; k++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      out_ready = hold ? 1'b0 : ((rcnt % 5) != 3);
      rcnt++;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R4 extra byte", out_data, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R3 R5 R6 R7 data", out_data, e[7:0]);
          chk(out_first == e[9], "R4 first", out_first, e[9]);
          chk(out_eom == e[8], "R8 eom", out_eom, e[8]);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    // R2 R3 R5 R6: sweep of lengths across padding boundaries
    for (int p = 1; p <= 100; p++) send_pkt(p, p);
    while (exp_q.size() != 0) @(negedge clk);
    // R9 R10: stall consumer, offer nine one-payload packets
    hold = 1'b1;
    fork
      begin
        for (int p = 0; p < 9; p++) send_pkt(40, 200 + p);
      end
    join_none
    repeat (800) @(negedge clk);
    #2;
    chk(in_ready == 1'b0, "R9 in_ready when full", in_ready, 0);
    chk(out_valid == 1'b1, "R9 out_valid when full", out_valid, 1);
    begin
      logic [7:0] d0;
      logic f0;
      d0 = out_data; f0 = out_first;
      repeat (40) @(negedge clk);
      #2;
      chk(out_data == d0, "R10 data held", out_data, d0);
      chk(out_first == f0 && out_valid, "R10 flags held", out_first, f0);
    end
    chk(exp_q.size() == 9 * 48, "R9 nothing taken early", exp_q.size(), 9 * 48);
    hold = 1'b0;
    wait fork;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R4 drained", out_valid, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule